// File: doc/BRIEF.md
# Framebuffer Display Scan Controller

This block drives a fixed-resolution true-colour panel from a frame buffer that sits in external memory. A host programs two 32-bit registers over a simple write/read register port: one holds the frame buffer base address, the other holds a display-on bit and a 180-degree flip bit. The block runs a free-running raster generator, works out the memory address of every visible pixel, reads it as a single word over a request/valid memory port, and puts the unpacked red, green and blue bytes on its pixel outputs. Sync and data-enable come out on the same clock as the pixel.

Each visible pixel is one 32-bit word. The byte at the top of the word is ignored, and the lower three bytes are red, green and blue. Rows are laid out in memory with a fixed stride that is wider than the visible width. The words past the visible width are never read. The base address keeps only its upper bits, so the buffer always starts on a large aligned boundary. A small prefetch FIFO sits between the memory port and the pixel output. It is emptied during vertical blank and filled again on the last blank line. If it runs dry during active video, the output goes black and a sticky error bit is set.

Top module: `fb_scan_ctrl`

## Requirements
- R1: After reset, both registers read 0, the display is off, no memory request is made and data-enable and the colour outputs are 0.
- R2: The base register keeps only bits 31:21 of a write. Bits 20:0 always read 0.
- R3: Register select uses byte address bit 2: 0 selects base and 1 selects control. Other address bits are ignored. In control, bit 0 is display-on and bit 1 is rotate. Bits 30:2 read 0, and writing bit 31 does not set it.
- R4: Hsync and vsync are active low. Hsync is low for HSW clocks of every line and vsync is low for VSW whole lines. Both keep running while the display is off.
- R5: Unrotated, visible pixel (x,y) is read from byte address base + (y*STRIDE + x)*4, in raster order.
- R6: Rotated, visible pixel (x,y) is read from byte address base + ((V_ACT-1-y)*STRIDE + (H_ACT-1-x))*4.
- R7: From each fetched word, bits 23:16 go to red, 15:8 to green and 7:0 to blue. Bits 31:24 have no effect.
- R8: While display-on is 0, no memory request is issued and data-enable and RGB are 0. Whenever data-enable is 0, RGB is 0.
- R9: With the display on and no underrun, each frame shows exactly H_ACT data-enable pixels on each of V_ACT lines.
- R10: If a pixel is due while the FIFO is empty, that pixel is black and control bit 31 becomes 1. The bit stays 1 until any write to control clears it.
- R11: FIFO occupancy plus reads in flight never exceeds FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address, bit 2 selects |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Single-word read request |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_rvalid_i | input | 1 | Read data valid, in request order |
| mem_rdata_i | input | 32 | Read data word |
| red_o | output | 8 | Red level |
| green_o | output | 8 | Green level |
| blue_o | output | 8 | Blue level |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable |

## Verification
The assertions assume the memory returns read data in request order, at most one word per clock, and only for requests it has received. They also assume every read issued before vertical blank returns before the last blank line, since returns that arrive during the flush window are dropped. The bench memory model has a fixed short latency and answers every request exactly once. The bench changes display-on or rotate only just after a vsync falling edge, except in the single case that deliberately turns the display on mid-line to cause an underrun.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int REG_W       = 32;
  localparam int CTRL_ON_BIT = 0;
  localparam int CTRL_ROT_BIT = 1;
  localparam int CTRL_UR_BIT = 31;

  typedef struct packed {
    logic [7:0] unused;
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } pix_word_t;
endpackage

// File: rtl/fb_scan_regs.sv
module fb_scan_regs
  import fb_scan_pkg::*;
#(
  parameter int BASE_KEEP = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_ctrl_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ur_set_i,
  output logic [REG_W-1:0] base_o,
  output logic             on_o,
  output logic             rot_o,
  output logic             ur_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int LOW_W = REG_W - BASE_KEEP;

  logic [BASE_KEEP-1:0] base_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_hi_q <= '0;
      on_o      <= 1'b0;
      rot_o     <= 1'b0;
      ur_o      <= 1'b0;
    end else begin
      if (we_i && !sel_ctrl_i) base_hi_q <= wdata_i[REG_W-1:LOW_W];
      if (we_i && sel_ctrl_i) begin
        on_o  <= wdata_i[CTRL_ON_BIT];
        rot_o <= wdata_i[CTRL_ROT_BIT];
        ur_o  <= 1'b0;
      end else if (ur_set_i) begin
        ur_o <= 1'b1;
      end
    end
  end

  assign base_o = {base_hi_q, {LOW_W{1'b0}}};

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl_i) begin
      rdata_o[CTRL_ON_BIT]  = on_o;
      rdata_o[CTRL_ROT_BIT] = rot_o;
      rdata_o[CTRL_UR_BIT]  = ur_o;
    end else begin
      rdata_o = base_o;
    end
  end
endmodule

// File: rtl/fb_scan_timing.sv
module fb_scan_timing #(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic active_o,
  output logic flush_o,
  output logic hs_n_o,
  output logic vs_n_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == HW'(H_TOT - 1)) begin
      h_q <= '0;
      v_q <= (v_q == VW'(V_TOT - 1)) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign active_o = (h_q < HW'(H_ACT)) && (v_q < VW'(V_ACT));
  // FIFO is held empty in vertical blank except the last line, which primes it
  assign flush_o  = (v_q >= VW'(V_ACT)) && (v_q != VW'(V_TOT - 1));
  assign hs_n_o   = !((h_q >= HW'(H_ACT + H_FP)) && (h_q < HW'(H_ACT + H_FP + H_SW)));
  assign vs_n_o   = !((v_q >= VW'(V_ACT + V_FP)) && (v_q < VW'(V_ACT + V_FP + V_SW)));
endmodule

// File: rtl/fb_scan_fetch.sv
module fb_scan_fetch
  import fb_scan_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int V_ACT  = 480,
  parameter int STRIDE = 1024,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             flush_i,
  input  logic             rot_i,
  input  logic [REG_W-1:0] base_i,
  input  logic             pop_i,
  input  logic             rvalid_i,
  input  logic [REG_W-1:0] rdata_i,
  output logic             req_o,
  output logic [REG_W-1:0] addr_o,
  output logic             empty_o,
  output logic [23:0]      head_o,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    pend_o
);
  localparam int XW = $clog2(H_ACT);
  localparam int YW = $clog2(V_ACT);
  localparam int PW = CW - 1;

  logic [XW-1:0] fx_q;
  logic [YW-1:0] fy_q;
  logic          done_q;
  logic [PW-1:0] wr_q, rd_q;
  logic [23:0]   mem_q [DEPTH];
  logic          push;
  logic [REG_W-1:0] row, col, idx;
  pix_word_t     in_word;

  assign req_o = run_i && !done_q &&
                 (({1'b0, count_o} + {1'b0, pend_o}) < (CW + 1)'(DEPTH));
  assign push  = rvalid_i && !flush_i;

  always_comb begin
    row    = rot_i ? REG_W'(V_ACT - 1) - REG_W'(fy_q) : REG_W'(fy_q);
    col    = rot_i ? REG_W'(H_ACT - 1) - REG_W'(fx_q) : REG_W'(fx_q);
    idx    = row * REG_W'(STRIDE) + col;
    addr_o = base_i + (idx << 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fx_q   <= '0;
      fy_q   <= '0;
      done_q <= 1'b0;
    end else if (flush_i) begin
      fx_q   <= '0;
      fy_q   <= '0;
      done_q <= 1'b0;
    end else if (req_o) begin
      if (fx_q == XW'(H_ACT - 1)) begin
        fx_q <= '0;
        if (fy_q == YW'(V_ACT - 1)) done_q <= 1'b1;
        else fy_q <= fy_q + 1'b1;
      end else begin
        fx_q <= fx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else pend_o <= pend_o + CW'(req_o) - CW'(rvalid_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_o <= count_o + CW'(push) - CW'(pop_i);
    end
  end

  assign in_word = pix_word_t'(rdata_i);

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= {in_word.red, in_word.green, in_word.blue};
  end

  assign empty_o = (count_o == '0);
  assign head_o  = mem_q[rd_q];
endmodule

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fb_scan_pkg::*;
#(
  parameter int H_ACT      = 640,
  parameter int H_FP       = 16,
  parameter int H_SW       = 96,
  parameter int H_BP       = 48,
  parameter int V_ACT      = 480,
  parameter int V_FP       = 10,
  parameter int V_SW       = 2,
  parameter int V_BP       = 33,
  parameter int STRIDE     = 1024,
  parameter int FIFO_DEPTH = 16,
  parameter int BASE_KEEP  = 11,
  parameter int SEL_BIT    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic [7:0]  red_o,
  output logic [7:0]  green_o,
  output logic [7:0]  blue_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic             ctrl_on, ctrl_rot, ctrl_ur, ur_set;
  logic [REG_W-1:0] base_addr;
  logic             active, flush, hs_n, vs_n;
  logic             fifo_empty, pix_due, pop;
  logic [23:0]      fifo_head;
  logic [CW-1:0]    fifo_cnt, fifo_pend;

  fb_scan_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .sel_ctrl_i(reg_addr_i[SEL_BIT]),
    .wdata_i   (reg_wdata_i),
    .ur_set_i  (ur_set),
    .base_o    (base_addr),
    .on_o      (ctrl_on),
    .rot_o     (ctrl_rot),
    .ur_o      (ctrl_ur),
    .rdata_o   (reg_rdata_o)
  );

  fb_scan_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni,
    .active_o(active),
    .flush_o (flush),
    .hs_n_o  (hs_n),
    .vs_n_o  (vs_n)
  );

  fb_scan_fetch #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .STRIDE(STRIDE), .DEPTH(FIFO_DEPTH)
  ) u_fetch (
    .clk_i, .rst_ni,
    .run_i   (ctrl_on && !flush),
    .flush_i (flush),
    .rot_i   (ctrl_rot),
    .base_i  (base_addr),
    .pop_i   (pop),
    .rvalid_i(mem_rvalid_i),
    .rdata_i (mem_rdata_i),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .empty_o (fifo_empty),
    .head_o  (fifo_head),
    .count_o (fifo_cnt),
    .pend_o  (fifo_pend)
  );

  assign pix_due = ctrl_on && active;
  assign pop     = pix_due && !fifo_empty;
  assign ur_set  = pix_due && fifo_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {red_o, green_o, blue_o} <= '0;
      de_o    <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else begin
      {red_o, green_o, blue_o} <= pop ? fifo_head : 24'h0;
      de_o    <= pix_due;
      hsync_o <= hs_n;
      vsync_o <= vs_n;
    end
  end
endmodule

// File: rtl/fb_scan_checker.sv
module fb_scan_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          on,
  input logic          ur,
  input logic          ctrl_wr,
  input logic          pix_due,
  input logic          empty,
  input logic          req,
  input logic          de,
  input logic [23:0]   rgb,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] pend
);
  p_no_read_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |-> !req);

  p_black_outside_de_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de |-> (rgb == 24'h0));

  p_black_on_underrun_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_due && empty) |=> (rgb == 24'h0) && ur);

  p_underrun_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ur && !ctrl_wr) |=> ur);

  p_credit_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt) + int'(pend)) <= DEPTH);
endmodule

bind fb_scan_ctrl fb_scan_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .on     (ctrl_on),
  .ur     (ctrl_ur),
  .ctrl_wr(reg_we_i && reg_addr_i[SEL_BIT]),
  .pix_due(pix_due),
  .empty  (fifo_empty),
  .req    (mem_req_o),
  .de     (de_o),
  .rgb    ({red_o, green_o, blue_o}),
  .cnt    (fifo_cnt),
  .pend   (fifo_pend)
);

// File: tb/fb_scan_ctrl_tb.sv
module fb_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 8, H_FP = 2, H_SW = 3, H_BP = 3;
  localparam int V_ACT = 4, V_FP = 1, V_SW = 2, V_BP = 2;
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int STRIDE = 16;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // R2/R3 register vectors
  localparam vec_t VECS [6] = '{
    '{4'h0, 32'hFFFF_FFFF, 4'h0, 32'hFFE0_0000},
    '{4'h0, 32'h001F_FFFF, 4'h0, 32'h0000_0000},
    '{4'h8, 32'h0060_0000, 4'h0, 32'h0060_0000},
    '{4'h4, 32'hFFFF_FFFE, 4'hC, 32'h0000_0002},
    '{4'hC, 32'h0000_0000, 4'h4, 32'h0000_0000},
    '{4'h0, 32'h007F_FFFF, 4'h8, 32'h0060_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [7:0]  red, green, blue;
  logic        hsync, vsync, de;

  logic        v1 = 1'b0, v2 = 1'b0, v3 = 1'b0;
  logic [31:0] a1 = '0, a2 = '0, a3 = '0;

  int checks = 0;
  int fails = 0;
  logic [31:0] base_val = 32'h0060_0000;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fb_scan_ctrl #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .STRIDE(STRIDE), .FIFO_DEPTH(DEPTH)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .red_o(red), .green_o(green), .blue_o(blue),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de)
  );

  // memory model: three-stage pipe, word = {0xC3, addr[25:2]}
  always @(posedge clk) begin
    v1 <= mem_req; a1 <= mem_addr;
    v2 <= v1;      a2 <= a1;
    v3 <= v2;      a3 <= a2;
  end
  assign mem_rvalid = v3;
  assign mem_rdata  = {8'hC3, a3[25:2]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_vs_fall();
    logic prev;
    prev = vsync;
    for (int i = 0; i < 4 * H_TOT * V_TOT; i++) begin
      @(negedge clk);
      if (prev && !vsync) return;
      prev = vsync;
    end
  endtask

  function automatic logic [23:0] exp_pix(input int p, input bit rot);
    int x, y, idx;
    logic [31:0] a;
    x = p % H_ACT;
    y = p / H_ACT;
    idx = rot ? (V_ACT - 1 - y) * STRIDE + (H_ACT - 1 - x) : y * STRIDE + x;
    a = base_val + 32'(idx * 4);
    return a[25:2];
  endfunction

  task automatic check_frame(input bit rot);
    int pix, lines, lc;
    logic prev_hs, prev_vs;
    logic [31:0] r;
    string tag;
    tag = rot ? "R6/R7" : "R5/R7";
    wait_vs_fall();
    wr(4'h4, {30'b0, rot, 1'b1});
    pix = 0; lines = 0; lc = 0;
    prev_hs = hsync; prev_vs = vsync;
    for (int i = 0; i < 2 * H_TOT * V_TOT; i++) begin
      @(negedge clk);
      if (prev_vs && !vsync) break;
      if (de) begin
        chk({red, green, blue} == exp_pix(pix, rot), tag,
            {8'h0, red, green, blue}, {8'h0, exp_pix(pix, rot)});
        pix++; lc++;
      end
      if (prev_hs && !hsync && lc != 0) begin
        chk(lc == H_ACT, "R9 line", 32'(lc), 32'(H_ACT));
        lines++; lc = 0;
      end
      prev_hs = hsync; prev_vs = vsync;
    end
    chk(pix == H_ACT * V_ACT, "R9 pixels", 32'(pix), 32'(H_ACT * V_ACT));
    chk(lines == V_ACT, "R9 lines", 32'(lines), 32'(V_ACT));
    rd(4'h4, r);
    chk(r == {30'b0, rot, 1'b1}, "R10 no underrun", r, {30'b0, rot, 1'b1});
  endtask

  initial begin
    logic [31:0] r;
    int cnt, reqs, des, colours, falls;
    logic prev;

    repeat (3) @(negedge clk);
    // R1: reset state
    rd(4'h0, r); chk(r == 0, "R1 base", r, 0);
    rd(4'h4, r); chk(r == 0, "R1 ctrl", r, 0);
    chk(!mem_req && !de && {red, green, blue} == 0, "R1 outputs",
        {29'b0, mem_req, de, |{red, green, blue}}, 0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, r);
      chk(r == VECS[i].ex, "R2/R3 vector", r, VECS[i].ex);
    end

    // R8 and R4: display off for a whole frame
    wr(4'h4, 32'h0);
    reqs = 0; des = 0; colours = 0; falls = 0;
    prev = hsync;
    for (int i = 0; i < H_TOT * V_TOT; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
      if (de) des++;
      if ({red, green, blue} != 0) colours++;
      if (prev && !hsync) falls++;
      prev = hsync;
    end
    chk(reqs == 0, "R8 requests", 32'(reqs), 0);
    chk(des == 0 && colours == 0, "R8 blank", 32'(des + colours), 0);
    chk(falls == V_TOT, "R4 hsync runs while off", 32'(falls), 32'(V_TOT));

    // R4: pulse widths
    prev = hsync;
    do begin @(negedge clk); if (prev && !hsync) break; prev = hsync; end while (1);
    cnt = 1;
    while (!hsync) begin @(negedge clk); if (!hsync) cnt++; end
    chk(cnt == H_SW, "R4 hsync width", 32'(cnt), 32'(H_SW));
    wait_vs_fall();
    cnt = 1;
    while (!vsync) begin @(negedge clk); if (!vsync) cnt++; end
    chk(cnt == V_SW * H_TOT, "R4 vsync width", 32'(cnt), 32'(V_SW * H_TOT));

    check_frame(1'b0);
    check_frame(1'b0);
    check_frame(1'b1);

    // R10: turn on mid-line with an empty FIFO
    wait_vs_fall();
    wr(4'h4, 32'h0);
    while (!vsync) @(negedge clk);
    repeat (2 * H_TOT + 2) @(negedge clk);
    wr(4'h4, 32'h1);
    wait_vs_fall();
    rd(4'h4, r);
    chk(r == 32'h8000_0001, "R10 sticky set", r, 32'h8000_0001);
    repeat (3) @(negedge clk);
    rd(4'h4, r);
    chk(r == 32'h8000_0001, "R10 sticky holds", r, 32'h8000_0001);
    wr(4'h4, 32'h1);
    rd(4'h4, r);
    chk(r == 32'h0000_0001, "R10 cleared by write", r, 32'h1);
    check_frame(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule